// File: doc/BRIEF.md
# PWM Dimming Duty Extractor

This block turns an external PWM dimming signal into an 8-bit brightness code. The input is sampled by a fast system clock. Each period is bounded by synchronized rising edges, and its high time and length are counted in clocks. A short sequential divider then rounds the ratio onto a 256-level scale. The code that drives the LED sinks is held stable and changes only when a new measurement lands at least two steps away from it. This masks one-step jitter on the input duty.

A line that stops toggling is handled apart from the measured path. If no rising edge comes within a programmable maximum period, the held code is forced to exactly 0x00 (line low) or 0xFF (line high). A line that stays low for a second, longer window raises a disable flag for the driver, and the next rising edge clears it. A line that stays high never raises that flag. At a 10 MHz clock the defaults give a 5 ms maximum period (200 Hz) and a 10 ms disable window. Inputs up to 10 kHz still give about a thousand clocks per period.

Top module: `pwm_duty_extractor`

## Requirements
- R1: After reset, `duty_code` is 0x00, `duty_valid` is 0 and `zero_disable` is 0.
- R2: For a period of P clocks with H high clocks (between synchronized rising edges), the measured code is floor((H*255 + floor(P/2)) / P). The first rising edge after reset, or after a constant-level timeout, only starts measuring and yields no code.
- R3: A measured code replaces the held code only when the two differ by 2 or more. A difference of 0 or 1 leaves `duty_code` unchanged.
- R4: `duty_valid` is high for exactly one clock each time `duty_code` takes a new value, and at no other time.
- R5: If MAX_PERIOD clocks pass after the last rising edge with no new one, `duty_code` becomes exactly 0x00 if the line is low or 0xFF if it is high. This ignores the step rule of R3.
- R6: `zero_disable` rises after the synchronized input has been low for DISABLE_CYCLES consecutive clocks, and not before.
- R7: A synchronized rising edge clears `zero_disable`.
- R8: A line held high, for any length of time, never sets `zero_disable`.
- R9: Between updates `duty_code` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the PWM input |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous PWM dimming input |
| duty_code | output | 8 | Held brightness code, 0x00 to 0xFF |
| duty_valid | output | 1 | One-clock strobe when `duty_code` changes |
| zero_disable | output | 1 | High after a sustained 0% input |

## Verification
A new code reaches `duty_code` 13 clocks after the input's rising edge. That is two synchronizer flops, the edge register, the sample register, eight divider steps and the hold register. The constant-level codes arrive 3 clocks after the timeout count is reached. The bench keeps a cycle model of the requirements and drives the input one clock per model step. It compares code and update count 40 clocks into the last period of each pattern, when no event can still be in flight. The disable flag is checked about 100 clocks before and 20 clocks after its window closes, which covers the synchronizer delay without depending on it.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;

  localparam int CODE_W   = 8;
  localparam int CODE_MAX = 255;

  typedef logic [CODE_W-1:0] code_t;

  // True when two codes are at least two steps apart (hysteresis rule).
  function automatic logic code_far(input code_t a, input code_t b);
    code_t d;
    d = (a > b) ? (a - b) : (b - a);
    return (d >= code_t'(2));
  endfunction

endpackage

// File: rtl/pwm_in_sync.sv
module pwm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              lvl_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~lvl_d;
endmodule

// File: rtl/pwm_period_meter.sv
module pwm_period_meter #(
  parameter int MAX_PERIOD = 50000,
  localparam int CNT_W     = $clog2(MAX_PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             rise,
  output logic             samp_stb,
  output logic [CNT_W-1:0] samp_high,
  output logic [CNT_W-1:0] samp_per,
  output logic             const_stb,
  output logic             const_lvl
);
  localparam logic [CNT_W-1:0] PER_SAT  = CNT_W'(MAX_PERIOD);
  localparam logic [CNT_W-1:0] PER_LAST = CNT_W'(MAX_PERIOD - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] high_cnt;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt   <= '0;
      high_cnt  <= '0;
      armed     <= 1'b0;
      samp_stb  <= 1'b0;
      samp_high <= '0;
      samp_per  <= '0;
      const_stb <= 1'b0;
      const_lvl <= 1'b0;
    end else begin
      samp_stb  <= 1'b0;
      const_stb <= 1'b0;
      if (rise) begin
        if (armed) begin
          samp_stb  <= 1'b1;
          samp_high <= high_cnt;
          samp_per  <= per_cnt;
        end
        armed    <= 1'b1;
        per_cnt  <= ONE;
        high_cnt <= ONE;
      end else if (per_cnt != PER_SAT) begin
        per_cnt  <= per_cnt + ONE;
        high_cnt <= high_cnt + CNT_W'(lvl);
        if (per_cnt == PER_LAST) begin
          const_stb <= 1'b1;
          const_lvl <= lvl;
          armed     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_duty_divider.sv
module pwm_duty_divider
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [CNT_W-1:0] per_cnt,
  output logic             done,
  output code_t            quot
);
  localparam int NUM_W = CNT_W + CODE_W;

  // Numerator of the rounded ratio: high*255 + per/2.
  function automatic logic [NUM_W-1:0] round_num(input logic [CNT_W-1:0] h,
                                                 input logic [CNT_W-1:0] p);
    logic [NUM_W-1:0] hw;
    hw = {{CODE_W{1'b0}}, h};
    return (hw << CODE_W) - hw + {{(CODE_W+1){1'b0}}, p[CNT_W-1:1]};
  endfunction

  logic [NUM_W-1:0] num;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] den;
  code_t            lo;
  logic [3:0]       steps;
  logic             busy;
  logic [CNT_W:0]   trial;
  logic             fits;
  logic [CNT_W-1:0] rem_sub;

  assign num     = round_num(high_cnt, per_cnt);
  assign trial   = {rem, lo[CODE_W-1]};
  assign fits    = (trial >= {1'b0, den});
  assign rem_sub = CNT_W'(trial - {1'b0, den});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      den   <= '0;
      lo    <= '0;
      quot  <= '0;
      steps <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && per_cnt != '0) begin
          // Quotient fits in CODE_W bits, so the upper part starts below den.
          rem   <= num[NUM_W-1:CODE_W];
          lo    <= num[CODE_W-1:0];
          den   <= per_cnt;
          quot  <= '0;
          steps <= 4'(CODE_W);
          busy  <= 1'b1;
        end
      end else begin
        rem   <= fits ? rem_sub : trial[CNT_W-1:0];
        quot  <= {quot[CODE_W-2:0], fits};
        lo    <= {lo[CODE_W-2:0], 1'b0};
        steps <= steps - 4'd1;
        if (steps == 4'd1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_code_hold.sv
module pwm_code_hold
  import pwm_duty_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  meas_done,
  input  code_t meas_code,
  input  logic  const_stb,
  input  logic  const_lvl,
  output code_t code,
  output logic  valid
);
  code_t forced;
  assign forced = {CODE_W{const_lvl}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (const_stb) begin
        if (forced != code) begin
          code  <= forced;
          valid <= 1'b1;
        end
      end else if (meas_done && code_far(meas_code, code)) begin
        code  <= meas_code;
        valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_zero_watch.sv
module pwm_zero_watch #(
  parameter int DISABLE_CYCLES = 100000,
  localparam int DIS_W         = $clog2(DISABLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise,
  output logic zero_flag
);
  localparam logic [DIS_W-1:0] LOW_SAT  = DIS_W'(DISABLE_CYCLES);
  localparam logic [DIS_W-1:0] LOW_LAST = DIS_W'(DISABLE_CYCLES - 1);

  logic [DIS_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      zero_flag <= 1'b0;
    end else if (lvl) begin
      low_cnt <= '0;
      if (rise) zero_flag <= 1'b0;
    end else if (low_cnt != LOW_SAT) begin
      low_cnt <= low_cnt + DIS_W'(1);
      if (low_cnt == LOW_LAST) zero_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_duty_extractor.sv
module pwm_duty_extractor
  import pwm_duty_pkg::*;
#(
  parameter int MAX_PERIOD     = 50000,
  parameter int DISABLE_CYCLES = 100000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwm_in,
  output logic [7:0]  duty_code,
  output logic        duty_valid,
  output logic        zero_disable
);
  localparam int CNT_W = $clog2(MAX_PERIOD + 1);

  // Named internal events, also observed by the bound checker.
  logic             sync_lvl;
  logic             edge_rise;
  logic             samp_stb;
  logic [CNT_W-1:0] samp_high;
  logic [CNT_W-1:0] samp_per;
  logic             const_stb;
  logic             const_lvl;
  logic             div_done;
  code_t            div_q;

  pwm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pwm_in),
    .lvl(sync_lvl), .rise(edge_rise)
  );

  pwm_period_meter #(.MAX_PERIOD(MAX_PERIOD)) u_meter (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .rise(edge_rise),
    .samp_stb(samp_stb), .samp_high(samp_high), .samp_per(samp_per),
    .const_stb(const_stb), .const_lvl(const_lvl)
  );

  pwm_duty_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(samp_stb),
    .high_cnt(samp_high), .per_cnt(samp_per),
    .done(div_done), .quot(div_q)
  );

  pwm_code_hold u_hold (
    .clk(clk), .rst_n(rst_n), .meas_done(div_done), .meas_code(div_q),
    .const_stb(const_stb), .const_lvl(const_lvl),
    .code(duty_code), .valid(duty_valid)
  );

  pwm_zero_watch #(.DISABLE_CYCLES(DISABLE_CYCLES)) u_zero (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .rise(edge_rise),
    .zero_flag(zero_disable)
  );
endmodule

// File: rtl/pwm_duty_extractor_chk.sv
module pwm_duty_extractor_chk
  import pwm_duty_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       lvl,
  input logic       rise,
  input logic       const_stb,
  input logic       const_lvl,
  input logic       div_done,
  input logic [7:0] code,
  input logic       valid,
  input logic       dis_flag
);
  AST_VALID_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (code != $past(code))); // R4
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(div_done) || $past(const_stb))); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(code)); // R9
  AST_HYST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$past(const_stb)) |-> code_far(code, $past(code))); // R3
  AST_CONST_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(const_stb) |-> (code == {8{$past(const_lvl)}})); // R5
  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_flag && rise) |=> !dis_flag); // R7
  AST_NO_DISABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && !rise) |-> !dis_flag); // R8
endmodule

bind pwm_duty_extractor pwm_duty_extractor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .rise(edge_rise),
  .const_stb(const_stb), .const_lvl(const_lvl), .div_done(div_done),
  .code(duty_code), .valid(duty_valid), .dis_flag(zero_disable)
);

// File: tb/pwm_duty_extractor_tb.sv
module pwm_duty_extractor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP       = 600;
  localparam int DISC       = 1500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic [7:0] duty_code;
  logic       duty_valid;
  logic       zero_disable;

  int tests = 0;
  int fails = 0;
  int seen_valid = 0;

  // Requirement model state
  logic m_prev = 1'b0;
  int   m_pc = 0, m_hc = 0, m_code = 0, m_updates = 0;
  bit   m_armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_duty_extractor #(.MAX_PERIOD(MAXP), .DISABLE_CYCLES(DISC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .duty_code(duty_code), .duty_valid(duty_valid), .zero_disable(zero_disable)
  );

  always @(negedge clk) if (rst_n && duty_valid) seen_valid++;

  function automatic int exp_code(int h, int p);
    return (h * 255 + p / 2) / p;
  endfunction

  function automatic bit far2(int a, int b);
    return (a > b ? a - b : b - a) >= 2;
  endfunction

  task automatic m_apply(int v, bit exact);
    if (exact ? (v != m_code) : far2(v, m_code)) begin
      m_code = v;
      m_updates++;
    end
  endtask

  task automatic check(string req, int got, int expv);
    tests++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  // One clock of stimulus plus the model of R2/R3/R5.
  task automatic tick(logic level);
    pwm_in = level;
    if (level && !m_prev) begin
      if (m_armed) m_apply(exp_code(m_hc, m_pc), 1'b0);
      m_armed = 1;
      m_pc = 1;
      m_hc = 1;
    end else if (m_pc != MAXP) begin
      m_pc++;
      m_hc += int'(level);
      if (m_pc == MAXP) begin
        m_apply(level ? 255 : 0, 1'b1);
        m_armed = 0;
      end
    end
    m_prev = level;
    @(negedge clk);
  endtask

  task automatic run_pattern(int p, int h, int n, string req);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < p; c++) begin
        tick(c < h);
        if (i == n - 1 && c == 40) begin
          check({req, " code"}, int'(duty_code), m_code);
          check("R4 update count", seen_valid, m_updates);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    check("R1 code", int'(duty_code), 0);
    check("R1 valid", int'(duty_valid), 0);
    check("R1 disable", int'(zero_disable), 0);
    rst_n = 1'b1;

    // Sustained 0% from reset
    repeat (1400) tick(1'b0);
    check("R6 early disable", int'(zero_disable), 0);
    repeat (120) tick(1'b0);
    check("R6 disable", int'(zero_disable), 1);
    check("R5 low code", int'(duty_code), 0);

    // First rising edge clears the flag
    repeat (5) tick(1'b1);
    check("R7 clear", int'(zero_disable), 0);
    repeat (50) tick(1'b0);

    // Directed hysteresis around code 128 (P=255)
    run_pattern(255, 128, 3, "R2");
    run_pattern(255, 129, 3, "R3 one up");
    run_pattern(255, 127, 3, "R3 one down");
    run_pattern(255, 130, 3, "R3 two up");

    // Constant high
    repeat (700) tick(1'b1);
    check("R5 high code", int'(duty_code), 255);
    check("R4 update count", seen_valid, m_updates);
    repeat (1600) tick(1'b1);
    check("R8 no disable", int'(zero_disable), 0);

    // Boundary patterns
    run_pattern(500, 499, 3, "R2 near full");
    run_pattern(500, 1, 3, "R2 near zero");
    run_pattern(599, 300, 3, "R2 longest period");

    // Random patterns
    for (int k = 0; k < 30; k++) begin
      int p, h;
      p = 60 + int'($urandom % 441);
      h = 1 + int'($urandom % (p - 1));
      run_pattern(p, h, 3, "R2 random");
    end

    // Back to sustained 0%
    repeat (700) tick(1'b0);
    check("R5 low exact", int'(duty_code), 0);
    check("R9 update count", seen_valid, m_updates);
    repeat (900) tick(1'b0);
    check("R6 disable again", int'(zero_disable), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule